// File: doc/BRIEF.md
# Integer Add/Subtract Execution Unit

This is a purely combinational 64-bit add/subtract unit for the integer pipeline of a processor core. An operation select picks one of fourteen arithmetic forms. Every form is reduced to one addition of three terms: a first addend, which is the first register operand, its bitwise complement, the constant zero or the next-instruction address; a second addend, which is the second register, an immediate in one of three shapes, all ones or zero; and a single carry-in bit, which is 0, 1, the carry status bit or the overflow status bit. Subtraction is therefore always formed as the complement of the first operand plus the second operand plus a carry-in.

The unit returns the 64-bit sum. It also reports the status values that the writeback stage would commit: carry out of the full width, signed overflow, the same pair for the low 32-bit word, and a less/greater/equal summary of the signed result for record-form instructions. Decoding, register reads and the update of architectural status registers belong to the surrounding pipeline.

Top module: `int_addsub_unit`

## Requirements
- R1: Operation code 0 (immediate add) yields 0 + EXTS(imm) when the first-operand index is 0, and raVal + EXTS(imm) for any other index, where EXTS sign-extends the 16-bit immediate to 64 bits.
- R2: Operation code 1 (shifted-immediate add) takes the 32-bit value {imm, 16'h0000}, sign-extends it to 64 bits, and adds it to 0 when the first-operand index is 0 and to raVal otherwise.
- R3: Operation code 2 (PC-relative add) builds a 16-bit D as {dHi[9:0], dMid[4:0], dLo}, with dHi as the most significant part, and returns nia + EXTS({D, 16'h0000}).
- R4: Operation code 3 returns raVal + rbVal. Code 4 (subtract-from) returns ~raVal + rbVal + 1. Code 5 returns ~raVal + EXTS(imm) + 1. None of the three uses the register-zero rule.
- R5: Operation code 6 returns raVal + rbVal + caIn, and code 7 returns ~raVal + rbVal + caIn.
- R6: Operation code 8 returns raVal + all-ones + caIn, and code 9 returns ~raVal + all-ones + caIn. Code 10 returns raVal + caIn, and code 11 returns ~raVal + caIn.
- R7: Operation code 12 (negate) returns ~raVal + 1.
- R8: Operation code 13 returns raVal + rbVal + ovIn, and caIn has no effect on it.
- R9: carryOut is the carry out of the most significant bit of the 64-bit addition. overflow is 1 exactly when the two addends have equal sign bits and the sign bit of the result differs from them.
- R10: carry32 is the carry out of the low 32-bit addition, with the same carry-in. overflow32 applies the rule of R9 to bit 31 of the addends and of the result.
- R11: Exactly one of lt, gt and eq is 1. lt means the result is negative as a signed 64-bit value, eq means it is zero, and gt means it is positive.
- R12: The unused operation codes 14 and 15 return a zero result with carryOut, overflow, carry32 and overflow32 all 0 and eq set, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opSel | input | 4 | Operation code (see requirements) |
| raIndex | input | 5 | Index of the first-operand register, 0 enables the literal-zero rule |
| raVal | input | 64 | First register operand |
| rbVal | input | 64 | Second register operand |
| imm | input | 16 | 16-bit immediate field |
| nia | input | 64 | Next-instruction address |
| dHi | input | 10 | Most significant split field of the PC-relative displacement |
| dMid | input | 5 | Middle split field of the displacement |
| dLo | input | 1 | Least significant split field of the displacement |
| caIn | input | 1 | Current carry status bit |
| ovIn | input | 1 | Current overflow status bit |
| result | output | 64 | Sum |
| carryOut | output | 1 | Carry out of the full width |
| overflow | output | 1 | Signed overflow of the full width |
| carry32 | output | 1 | Carry out of the low word |
| overflow32 | output | 1 | Signed overflow of the low word |
| lt | output | 1 | Result is negative |
| gt | output | 1 | Result is positive |
| eq | output | 1 | Result is zero |

## Verification
Every output is due in the same cycle as the inputs that produce it, because no register lies between the inputs and the outputs. The bench changes the inputs just after a falling clock edge and samples the outputs two nanoseconds later, so the adder path has settled and no rising edge falls between stimulus and sample. Each sample is compared with an expected sum written out by hand for the scenario, and with flags that the bench derives independently from the addend rules of R9 and R10.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

  typedef enum logic [3:0] {
    OP_ADD_IMM   = 4'd0,
    OP_ADD_SHIMM = 4'd1,
    OP_ADD_PCREL = 4'd2,
    OP_ADD_REG   = 4'd3,
    OP_SUBF_REG  = 4'd4,
    OP_SUBF_IMM  = 4'd5,
    OP_ADD_EXT   = 4'd6,
    OP_SUBF_EXT  = 4'd7,
    OP_ADD_ME    = 4'd8,
    OP_SUBF_ME   = 4'd9,
    OP_ADD_ZE    = 4'd10,
    OP_SUBF_ZE   = 4'd11,
    OP_NEG       = 4'd12,
    OP_ADD_OVCIN = 4'd13,
    OP_RSVD_14   = 4'd14,
    OP_RSVD_15   = 4'd15
  } op_e;

  typedef enum logic [1:0] {
    A_REG  = 2'd0,
    A_ZERO = 2'd1,
    A_NIA  = 2'd2
  } asel_e;

  typedef enum logic [2:0] {
    B_REG   = 3'd0,
    B_IMM   = 3'd1,
    B_SHIMM = 3'd2,
    B_PCIMM = 3'd3,
    B_ONES  = 3'd4,
    B_ZERO  = 3'd5
  } bsel_e;

  typedef enum logic [1:0] {
    C_ZERO = 2'd0,
    C_ONE  = 2'd1,
    C_CA   = 2'd2,
    C_OV   = 2'd3
  } csel_e;

  typedef struct packed {
    asel_e aSel;
    logic  invA;
    bsel_e bSel;
    csel_e cSel;
  } strobe_t;

endpackage

// File: rtl/addsub_ctrl.sv
module addsub_ctrl
  import addsub_pkg::*;
#(
  parameter int IDXW = 5
) (
  input  logic [3:0]      opSel,
  input  logic [IDXW-1:0] raIndex,
  output strobe_t         strobe
);

  logic raZero;
  assign raZero = (raIndex == '0);

  always_comb begin
    strobe = '{aSel: A_REG, invA: 1'b0, bSel: B_REG, cSel: C_ZERO};
    case (op_e'(opSel))
      OP_ADD_IMM: begin
        strobe.aSel = raZero ? A_ZERO : A_REG;
        strobe.bSel = B_IMM;
      end
      OP_ADD_SHIMM: begin
        strobe.aSel = raZero ? A_ZERO : A_REG;
        strobe.bSel = B_SHIMM;
      end
      OP_ADD_PCREL: begin
        strobe.aSel = A_NIA;
        strobe.bSel = B_PCIMM;
      end
      OP_ADD_REG: ;
      OP_SUBF_REG: begin
        strobe.invA = 1'b1;
        strobe.cSel = C_ONE;
      end
      OP_SUBF_IMM: begin
        strobe.invA = 1'b1;
        strobe.bSel = B_IMM;
        strobe.cSel = C_ONE;
      end
      OP_ADD_EXT: strobe.cSel = C_CA;
      OP_SUBF_EXT: begin
        strobe.invA = 1'b1;
        strobe.cSel = C_CA;
      end
      OP_ADD_ME: begin
        strobe.bSel = B_ONES;
        strobe.cSel = C_CA;
      end
      OP_SUBF_ME: begin
        strobe.invA = 1'b1;
        strobe.bSel = B_ONES;
        strobe.cSel = C_CA;
      end
      OP_ADD_ZE: begin
        strobe.bSel = B_ZERO;
        strobe.cSel = C_CA;
      end
      OP_SUBF_ZE: begin
        strobe.invA = 1'b1;
        strobe.bSel = B_ZERO;
        strobe.cSel = C_CA;
      end
      OP_NEG: begin
        strobe.invA = 1'b1;
        strobe.bSel = B_ZERO;
        strobe.cSel = C_ONE;
      end
      OP_ADD_OVCIN: strobe.cSel = C_OV;
      default: begin
        strobe.aSel = A_ZERO;
        strobe.bSel = B_ZERO;
      end
    endcase
  end

endmodule

// File: rtl/addsub_datapath.sv
module addsub_datapath
  import addsub_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int IMMW  = 16,
  parameter int WORDW = 32,
  parameter int DHIW  = 10,
  parameter int DMIDW = 5,
  parameter int DLOW  = 1
) (
  input  strobe_t           strobe,
  input  logic [XLEN-1:0]   raVal,
  input  logic [XLEN-1:0]   rbVal,
  input  logic [IMMW-1:0]   imm,
  input  logic [XLEN-1:0]   nia,
  input  logic [DHIW-1:0]   dHi,
  input  logic [DMIDW-1:0]  dMid,
  input  logic [DLOW-1:0]   dLo,
  input  logic              caIn,
  input  logic              ovIn,
  output logic [XLEN-1:0]   result,
  output logic              carryOut,
  output logic              overflow,
  output logic              carry32,
  output logic              overflow32,
  output logic              lt,
  output logic              gt,
  output logic              eq
);

  localparam int SHW = 2 * IMMW;
  localparam int DW  = DHIW + DMIDW + DLOW;

  logic [IMMW-1:0] dCat;
  logic [XLEN-1:0] immExt, shImmExt, pcImmExt;
  logic [XLEN-1:0] addA, addB, baseA;
  logic            cin;
  logic [XLEN:0]   wideSum;
  logic [WORDW:0]  wordSum;

  assign dCat     = IMMW'({dHi, dMid, dLo});
  assign immExt   = {{(XLEN-IMMW){imm[IMMW-1]}}, imm};
  assign shImmExt = {{(XLEN-SHW){imm[IMMW-1]}}, imm, {IMMW{1'b0}}};
  assign pcImmExt = {{(XLEN-SHW){dCat[DW-1]}}, dCat, {IMMW{1'b0}}};

  always_comb begin
    case (strobe.aSel)
      A_REG:   baseA = raVal;
      A_NIA:   baseA = nia;
      default: baseA = '0;
    endcase
    addA = strobe.invA ? ~baseA : baseA;
  end

  always_comb begin
    case (strobe.bSel)
      B_REG:   addB = rbVal;
      B_IMM:   addB = immExt;
      B_SHIMM: addB = shImmExt;
      B_PCIMM: addB = pcImmExt;
      B_ONES:  addB = '1;
      default: addB = '0;
    endcase
  end

  always_comb begin
    case (strobe.cSel)
      C_ONE:   cin = 1'b1;
      C_CA:    cin = caIn;
      C_OV:    cin = ovIn;
      default: cin = 1'b0;
    endcase
  end

  assign wideSum = {1'b0, addA} + {1'b0, addB} + {{XLEN{1'b0}}, cin};
  assign wordSum = {1'b0, addA[WORDW-1:0]} + {1'b0, addB[WORDW-1:0]}
                 + {{WORDW{1'b0}}, cin};

  assign result     = wideSum[XLEN-1:0];
  assign carryOut   = wideSum[XLEN];
  assign carry32    = wordSum[WORDW];
  assign overflow   = (addA[XLEN-1] == addB[XLEN-1]) &&
                      (wideSum[XLEN-1] != addA[XLEN-1]);
  assign overflow32 = (addA[WORDW-1] == addB[WORDW-1]) &&
                      (wordSum[WORDW-1] != addA[WORDW-1]);

  assign eq = (wideSum[XLEN-1:0] == '0);
  assign lt = wideSum[XLEN-1];
  assign gt = !eq && !wideSum[XLEN-1];

endmodule

// File: rtl/int_addsub_unit.sv
module int_addsub_unit
  import addsub_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int IMMW  = 16,
  parameter int IDXW  = 5,
  parameter int DMIDW = 5,
  parameter int DLOW  = 1,
  localparam int DHIW = IMMW - DMIDW - DLOW
) (
  input  logic [3:0]       opSel,
  input  logic [IDXW-1:0]  raIndex,
  input  logic [XLEN-1:0]  raVal,
  input  logic [XLEN-1:0]  rbVal,
  input  logic [IMMW-1:0]  imm,
  input  logic [XLEN-1:0]  nia,
  input  logic [DHIW-1:0]  dHi,
  input  logic [DMIDW-1:0] dMid,
  input  logic [DLOW-1:0]  dLo,
  input  logic             caIn,
  input  logic             ovIn,
  output logic [XLEN-1:0]  result,
  output logic             carryOut,
  output logic             overflow,
  output logic             carry32,
  output logic             overflow32,
  output logic             lt,
  output logic             gt,
  output logic             eq
);

  strobe_t strobe;

  addsub_ctrl #(.IDXW(IDXW)) u_ctrl (
    .opSel   (opSel),
    .raIndex (raIndex),
    .strobe  (strobe)
  );

  addsub_datapath #(
    .XLEN(XLEN), .IMMW(IMMW), .WORDW(XLEN/2),
    .DHIW(DHIW), .DMIDW(DMIDW), .DLOW(DLOW)
  ) u_dp (
    .strobe     (strobe),
    .raVal      (raVal),
    .rbVal      (rbVal),
    .imm        (imm),
    .nia        (nia),
    .dHi        (dHi),
    .dMid       (dMid),
    .dLo        (dLo),
    .caIn       (caIn),
    .ovIn       (ovIn),
    .result     (result),
    .carryOut   (carryOut),
    .overflow   (overflow),
    .carry32    (carry32),
    .overflow32 (overflow32),
    .lt         (lt),
    .gt         (gt),
    .eq         (eq)
  );

endmodule

// File: rtl/addsub_checker.sv
module addsub_checker #(
  parameter int XLEN = 64,
  parameter int IMMW = 16,
  parameter int IDXW = 5
) (
  input logic [3:0]      opSel,
  input logic [IDXW-1:0] raIndex,
  input logic [XLEN-1:0] raVal,
  input logic [XLEN-1:0] rbVal,
  input logic [IMMW-1:0] imm,
  input logic            ovIn,
  input logic [XLEN-1:0] result,
  input logic            carryOut,
  input logic            overflow,
  input logic            lt,
  input logic            gt,
  input logic            eq
);

  logic known;
  assign known = !$isunknown({opSel, raIndex, raVal, rbVal, imm, ovIn, result});

  always_comb begin
    if (known) begin
      // R11: one condition bit only
      a_r11_one_cond: assert ($countones({lt, gt, eq}) == 1);
      // R1: literal-zero base for index 0
      if (opSel == 4'd0 && raIndex == '0)
        a_r1_zero_index: assert (result == {{(XLEN-IMMW){imm[IMMW-1]}}, imm});
      // R4: register add with carry
      if (opSel == 4'd3)
        a_r4_add_reg: assert ({carryOut, result} == ({1'b0, raVal} + {1'b0, rbVal}));
      // R4: subtract-from is a difference
      if (opSel == 4'd4)
        a_r4_subf_diff: assert (result == rbVal - raVal);
      // R7: negate
      if (opSel == 4'd12)
        a_r7_negate: assert (result == '0 - raVal);
      // R8: overflow bit feeds the carry-in
      if (opSel == 4'd13)
        a_r8_ov_cin: assert (result == raVal + rbVal + {{(XLEN-1){1'b0}}, ovIn});
      // R12: unused codes give zero
      if (opSel[3:1] == 3'b111)
        a_r12_reserved: assert (result == '0 && !carryOut && !overflow && eq);
    end
  end

endmodule

bind int_addsub_unit addsub_checker #(.XLEN(XLEN), .IMMW(IMMW), .IDXW(IDXW)) u_chk (.*);

// File: tb/sim_int_addsub_unit.sv
`timescale 1ns/1ps
module sim_int_addsub_unit;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [3:0]  opSel;
  logic [4:0]  raIndex;
  logic [63:0] raVal, rbVal, nia;
  logic [15:0] imm;
  logic [9:0]  dHi;
  logic [4:0]  dMid;
  logic [0:0]  dLo;
  logic        caIn, ovIn;
  logic [63:0] result;
  logic        carryOut, overflow, carry32, overflow32, lt, gt, eq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int_addsub_unit u0 (.*);

  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  function automatic logic [63:0] sx16(input logic [15:0] v);
    return {{48{v[15]}}, v};
  endfunction

  task automatic drive(input logic [3:0] op, input logic [4:0] idx,
                       input logic [63:0] a, input logic [63:0] b,
                       input logic [15:0] im, input logic ca, input logic ov);
    @(negedge clk);
    opSel = op; raIndex = idx; raVal = a; rbVal = b; imm = im;
    caIn = ca; ovIn = ov;
    #2;
  endtask

  // expected flags from the addend rules (R9, R10, R11)
  task automatic chk(input string tag, input logic [63:0] expRes,
                     input logic [63:0] ea, input logic [63:0] eb, input logic cin);
    logic [64:0] w;
    logic [32:0] w32;
    logic [63:0] r;
    logic eC, eV, eC32, eV32, eLt, eGt, eEq;
    w    = {1'b0, ea} + {1'b0, eb} + {64'd0, cin};
    w32  = {1'b0, ea[31:0]} + {1'b0, eb[31:0]} + {32'd0, cin};
    r    = w[63:0];
    eC   = w[64];
    eC32 = w32[32];
    eV   = (ea[63] == eb[63]) && (r[63] != ea[63]);
    eV32 = (ea[31] == eb[31]) && (w32[31] != ea[31]);
    eEq  = (r == 0);
    eLt  = r[63];
    eGt  = !eEq && !eLt;
    checks++;
    if (result !== expRes || r !== expRes ||
        {carryOut, overflow, carry32, overflow32, lt, gt, eq} !==
        {eC, eV, eC32, eV32, eLt, eGt, eEq}) begin
      failures++;
      $display("FAIL %s: got res=%h flags=%b exp res=%h flags=%b", tag, result,
               {carryOut, overflow, carry32, overflow32, lt, gt, eq}, expRes,
               {eC, eV, eC32, eV32, eLt, eGt, eEq});
    end
  endtask

  task automatic t_idle;
    drive(4'd0, 5'd0, 64'd0, 64'd0, 16'd0, 1'b0, 1'b0);
    chk("R11 idle zero", 64'd0, 64'd0, 64'd0, 1'b0);
  endtask

  task automatic t_imm;
    drive(4'd0, 5'd0, 64'h1234, 64'd0, 16'hFFFE, 1'b1, 1'b1);
    chk("R1 index0 literal zero", ONES - 64'd1, 64'd0, sx16(16'hFFFE), 1'b0);
    drive(4'd0, 5'd3, 64'd10, 64'd0, 16'hFFFE, 1'b0, 1'b0);
    chk("R1 reg plus imm, R9 carry", 64'd8, 64'd10, sx16(16'hFFFE), 1'b0);
  endtask

  task automatic t_shimm;
    drive(4'd1, 5'd0, 64'h55, 64'd0, 16'h8000, 1'b0, 1'b0);
    chk("R2 index0 shifted", 64'hFFFF_FFFF_8000_0000, 64'd0, 64'hFFFF_FFFF_8000_0000, 1'b0);
    drive(4'd1, 5'd5, 64'h1_0000, 64'd0, 16'h0001, 1'b0, 1'b0);
    chk("R2 reg plus shifted", 64'h2_0000, 64'h1_0000, 64'h1_0000, 1'b0);
  endtask

  task automatic t_pcrel;
    nia = 64'h1000; dHi = 10'h3FF; dMid = 5'h1F; dLo = 1'b1;
    drive(4'd2, 5'd7, 64'h99, 64'h77, 16'h0, 1'b0, 1'b0);
    chk("R3 negative disp", 64'hFFFF_FFFF_FFFF_1000, 64'h1000, 64'hFFFF_FFFF_FFFF_0000, 1'b0);
    dHi = 10'h001; dMid = 5'h00; dLo = 1'b0;
    drive(4'd2, 5'd7, 64'h99, 64'h77, 16'h0, 1'b0, 1'b0);
    chk("R3 high field order", 64'h40_1000, 64'h1000, 64'h40_0000, 1'b0);
    dHi = 10'h000; dMid = 5'h01; dLo = 1'b1;
    drive(4'd2, 5'd7, 64'h99, 64'h77, 16'h0, 1'b0, 1'b0);
    chk("R3 mid and low fields", 64'h3_1000, 64'h1000, 64'h3_0000, 1'b0);
    dHi = '0; dMid = '0; dLo = '0; nia = '0;
  endtask

  task automatic t_addsub;
    drive(4'd3, 5'd0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 16'h0, 1'b1, 1'b0);
    chk("R4 add reg, R9 overflow", 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 1'b0);
    drive(4'd4, 5'd0, 64'd5, 64'd3, 16'h0, 1'b0, 1'b0);
    chk("R4 subf negative", ONES - 64'd1, ~64'd5, 64'd3, 1'b1);
    drive(4'd4, 5'd0, 64'd3, 64'd5, 16'h0, 1'b0, 1'b0);
    chk("R4 subf positive, R9 carry", 64'd2, ~64'd3, 64'd5, 1'b1);
    drive(4'd4, 5'd0, 64'd1, 64'h8000_0000_0000_0000, 16'h0, 1'b0, 1'b0);
    chk("R9 subf overflow", 64'h7FFF_FFFF_FFFF_FFFF, ~64'd1, 64'h8000_0000_0000_0000, 1'b1);
    drive(4'd5, 5'd0, 64'd1, 64'hDEAD, 16'h0010, 1'b0, 1'b0);
    chk("R4 subf imm index0 uses reg", 64'd15, ~64'd1, 64'd16, 1'b1);
  endtask

  task automatic t_ext;
    drive(4'd6, 5'd0, ONES, 64'd0, 16'h0, 1'b1, 1'b0);
    chk("R5 add ext carry in", 64'd0, ONES, 64'd0, 1'b1);
    drive(4'd7, 5'd0, 64'd5, 64'd3, 16'h0, 1'b0, 1'b0);
    chk("R5 subf ext no carry", ONES - 64'd2, ~64'd5, 64'd3, 1'b0);
  endtask

  task automatic t_mezero;
    drive(4'd8, 5'd0, 64'd0, 64'h5, 16'h0, 1'b0, 1'b0);
    chk("R6 add minus one ca0", ONES, 64'd0, ONES, 1'b0);
    drive(4'd8, 5'd0, 64'd0, 64'h5, 16'h0, 1'b1, 1'b0);
    chk("R6 add minus one ca1", 64'd0, 64'd0, ONES, 1'b1);
    drive(4'd9, 5'd0, 64'd0, 64'h5, 16'h0, 1'b0, 1'b0);
    chk("R6 subf minus one", ONES - 64'd1, ONES, ONES, 1'b0);
    drive(4'd10, 5'd0, 64'd7, 64'h5, 16'h0, 1'b1, 1'b0);
    chk("R6 add zero", 64'd8, 64'd7, 64'd0, 1'b1);
    drive(4'd11, 5'd0, 64'd7, 64'h5, 16'h0, 1'b0, 1'b0);
    chk("R6 subf zero", ~64'd7, ~64'd7, 64'd0, 1'b0);
  endtask

  task automatic t_neg;
    drive(4'd12, 5'd0, 64'd5, 64'h9, 16'h0, 1'b0, 1'b0);
    chk("R7 negate five", ONES - 64'd4, ~64'd5, 64'd0, 1'b1);
    drive(4'd12, 5'd0, 64'd0, 64'h9, 16'h0, 1'b0, 1'b0);
    chk("R7 negate zero carry", 64'd0, ONES, 64'd0, 1'b1);
    drive(4'd12, 5'd0, 64'h8000_0000_0000_0000, 64'h9, 16'h0, 1'b0, 1'b0);
    chk("R7 negate min overflow", 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 64'd0, 1'b1);
  endtask

  task automatic t_ovcin;
    drive(4'd13, 5'd0, 64'd1, 64'd2, 16'h0, 1'b0, 1'b1);
    chk("R8 ov as carry", 64'd4, 64'd1, 64'd2, 1'b1);
    drive(4'd13, 5'd0, 64'd1, 64'd2, 16'h0, 1'b1, 1'b0);
    chk("R8 ca ignored", 64'd3, 64'd1, 64'd2, 1'b0);
  endtask

  task automatic t_word;
    drive(4'd3, 5'd0, 64'hFFFF_FFFF, 64'd1, 16'h0, 1'b0, 1'b0);
    chk("R10 word carry", 64'h1_0000_0000, 64'hFFFF_FFFF, 64'd1, 1'b0);
    drive(4'd3, 5'd0, 64'h7FFF_FFFF, 64'd1, 16'h0, 1'b0, 1'b0);
    chk("R10 word overflow", 64'h8000_0000, 64'h7FFF_FFFF, 64'd1, 1'b0);
  endtask

  task automatic t_reserved;
    for (int k = 14; k < 16; k++) begin
      drive(4'(k), 5'd9, ONES, ONES, 16'hFFFF, 1'b1, 1'b1);
      chk("R12 unused code", 64'd0, 64'd0, 64'd0, 1'b0);
    end
  endtask

  initial begin
    opSel = '0; raIndex = '0; raVal = '0; rbVal = '0; imm = '0; nia = '0;
    dHi = '0; dMid = '0; dLo = '0; caIn = 1'b0; ovIn = 1'b0;
    repeat (2) @(posedge clk);
    t_idle;
    t_imm;
    t_shimm;
    t_pcrel;
    t_addsub;
    t_ext;
    t_mezero;
    t_neg;
    t_ovcin;
    t_word;
    t_reserved;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule